// File: doc/BRIEF.md
# Accumulator Move Limiter and Extender

This block is the data path a DSP core uses when a value crosses between a 56-bit accumulator and a narrower register. An accumulator is held as an 8-bit extension byte above a 24-bit high word and a 24-bit low word. On a read, the whole accumulator can first be scaled by one bit position. A mode field taken from the status register picks the direction. If the scaled value no longer fits a 24-bit word, a saturation constant is stored in its place. A 16-bit destination receives the low 16 bits of that limited word. A read of only the high word or only the low word bypasses both the scaling and the limiting.

On a write, the block widens a 16-bit or 24-bit source either into a 24-bit register or into a full accumulator. It also holds the seven condition-code flags. The limit flag among them is sticky: a limiting read sets it and it stays set until software clears it. A move whose destination is the status register loads all seven flags straight from the source bits.

Decode sits outside the block. It presents one read-side transfer and one write-side transfer per cycle. The data paths are combinational. Only the flags are registered.

Top module: `acc_move_unit`

## Requirements
- R1: For a full-accumulator source the value is scaled before limiting, according to `scale_mode`. Code 00 leaves it unchanged. Code 01 is an arithmetic right shift by one. Code 10 is a left shift by one with a zero shifted in. Code 11 behaves as 00.
- R2: After scaling, if bits 55 down to 47 are all equal, `rd_data` is bits 47 down to 24 of the scaled value and `rd_limited` is 0.
- R3: After scaling, if bits 55 down to 47 are not all equal, `rd_limited` is 1 and a 24-bit `rd_data` is limited. It is 0x7FFFFF when bit 55 is 0 and 0x800000 when bit 55 is 1.
- R4: With `rd_dst_narrow` = 1 the limiting of R2/R3 is applied first. `rd_data` then carries only the low 16 bits of the result, with bits 23 to 16 forced to zero.
- R5: `rd_src_sel` 01 selects the high word (bits 47..24) and 10 or 11 selects the low word (bits 23..0). For these partial sources there is no scaling and no limiting: `rd_limited` stays 0 and the word passes through (low 16 bits only when narrow).
- R6: The limit flag (`cc_flags` bit 6) is set on a clock edge where `rd_valid` and `rd_limited` are both 1. It then holds through any later moves until `l_clear` is seen. A limiting read in the same cycle as `l_clear` leaves it set.
- R7: With `wr_to_acc` = 1 and a 24-bit source, `wr_acc` is the source sign-extended from bit 23 into bits 55..48, placed in bits 47..24, with bits 23..0 zero.
- R8: With `wr_src_narrow` = 1, `wr_reg` is the low 16 bits of `wr_src` with bits 23..16 zero.
- R9: With `wr_src_narrow` = 1 and `wr_to_acc` = 1, the source is first zero-extended to 24 bits and then widened as in R7, so the extension byte is always zero.
- R10: With a 24-bit source, `wr_reg` equals `wr_src` unchanged.
- R11: When `ccr_load` is 1, the next edge loads `cc_flags` (L,E,U,N,Z,V,C at bits 6..0) from `wr_src[6:0]`. This load takes priority over limit setting and over `l_clear`. Flags E..C change only through this load.
- R12: While `rst_n` is low, `cc_flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | A read-side move happens this cycle |
| rd_src_sel | input | 2 | 00 full accumulator, 01 high word, 10/11 low word |
| scale_mode | input | 2 | Scaling mode bits from the status register |
| rd_dst_narrow | input | 1 | Read destination is 16 bits wide |
| rd_acc | input | 56 | Accumulator value being read |
| rd_data | output | 24 | Scaled, limited or passed word for the destination |
| rd_limited | output | 1 | The current read is being limited |
| wr_src | input | 24 | Write-side source word (16-bit sources use bits 15..0) |
| wr_src_narrow | input | 1 | Write-side source is 16 bits wide |
| wr_to_acc | input | 1 | Write destination is a full accumulator |
| wr_acc | output | 56 | Widened value for an accumulator destination |
| wr_reg | output | 24 | Widened value for a 24-bit register destination |
| ccr_load | input | 1 | Destination is the status register: load flags from wr_src |
| l_clear | input | 1 | Clear the sticky limit flag |
| cc_flags | output | 7 | Condition-code flags L,E,U,N,Z,V,C (bit 6..0) |

## Verification
The bench builds the block with its default parameters: an 8-bit extension, 24-bit words and a 16-bit narrow width. With those values the saturation constants and the 9-bit in-use window can be written down by hand as exact hexadecimal vectors. The same goes for the 16-bit truncation. The vectors then cover the edge of the in-use window: a value whose top nine bits are all ones passes unlimited, while one more extension bit saturates. They also cover a right shift that brings an overflowing value back into range and a left shift that carries a low-word bit upward.

// File: rtl/acc_mv_pkg.sv
// Package: shared encodings for the accumulator move unit.
// Assumes the flag vector is ordered L,E,U,N,Z,V,C from bit 6 down to bit 0.
package acc_mv_pkg;

    typedef enum logic [1:0] {
        SRC_FULL = 2'b00,
        SRC_HIGH = 2'b01,
        SRC_LOW  = 2'b10,
        SRC_LOW2 = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        SCL_NONE = 2'b00,
        SCL_DOWN = 2'b01,
        SCL_UP   = 2'b10,
        SCL_RSVD = 2'b11
    } scale_e;

    localparam int FLAG_W  = 7;
    localparam int FLAG_L  = 6;

endpackage

// File: rtl/acc_scaler.sv
// acc_scaler: applies the status-register scaling mode to a full accumulator.
// Assumes the mode is decoded per acc_mv_pkg::scale_e; the reserved code is a pass.
module acc_scaler #(
    parameter int ACC_W = 56
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [1:0]       mode,
    output logic [ACC_W-1:0] acc_out
);
    import acc_mv_pkg::*;

    // Select the one-bit shift variant requested by the mode.
    always_comb begin
        unique case (scale_e'(mode))
            SCL_DOWN: acc_out = {acc_in[ACC_W-1], acc_in[ACC_W-1:1]};
            SCL_UP:   acc_out = {acc_in[ACC_W-2:0], 1'b0};
            default:  acc_out = acc_in;
        endcase
    end
endmodule

// File: rtl/acc_limiter.sv
// acc_limiter: decides whether a scaled accumulator fits one word and saturates it if not.
// Assumes ACC_W = EXT_W + 2*WORD_W and NARROW_W < WORD_W.
module acc_limiter #(
    parameter int EXT_W    = 8,
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 16
) (
    input  logic [EXT_W+2*WORD_W-1:0] scaled,
    output logic [WORD_W-1:0]         word_out,
    output logic                      in_use
);
    localparam int ACC_W  = EXT_W + 2*WORD_W;
    localparam int CHK_LO = 2*WORD_W - 1;
    localparam int CHK_W  = ACC_W - CHK_LO;

    logic [CHK_W-1:0]  top_bits;
    logic [WORD_W-1:0] pos_sat;
    logic [WORD_W-1:0] neg_sat;

    // Gather the extension plus the high-word sign bit for the fit test.
    always_comb begin
        top_bits = scaled[ACC_W-1:CHK_LO];
        in_use   = !((top_bits == '0) || (top_bits == '1));
    end

    // Build the two saturation constants for the word width.
    always_comb begin
        pos_sat = {1'b0, {(WORD_W-1){1'b1}}};
        neg_sat = {1'b1, {(WORD_W-1){1'b0}}};
    end

    // Pick the high word or the constant matching the sign.
    always_comb begin
        if (!in_use)
            word_out = scaled[2*WORD_W-1:WORD_W];
        else if (scaled[ACC_W-1])
            word_out = neg_sat;
        else
            word_out = pos_sat;
    end
endmodule

// File: rtl/acc_read_path.sv
// acc_read_path: full read-side path from accumulator to destination word.
// Assumes partial sources bypass scaling and limiting; narrow results are zero-padded.
module acc_read_path #(
    parameter int EXT_W    = 8,
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 16
) (
    input  logic [EXT_W+2*WORD_W-1:0] acc_in,
    input  logic [1:0]                src_sel,
    input  logic [1:0]                mode,
    input  logic                      dst_narrow,
    output logic [WORD_W-1:0]         data_out,
    output logic                      limited
);
    import acc_mv_pkg::*;

    localparam int ACC_W = EXT_W + 2*WORD_W;
    localparam int PAD_W = WORD_W - NARROW_W;

    logic [ACC_W-1:0]  scaled;
    logic [WORD_W-1:0] lim_word;
    logic              ovf;
    logic [WORD_W-1:0] pre_trunc;

    acc_scaler #(.ACC_W(ACC_W)) u_scale (
        .acc_in  (acc_in),
        .mode    (mode),
        .acc_out (scaled)
    );

    acc_limiter #(.EXT_W(EXT_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_lim (
        .scaled   (scaled),
        .word_out (lim_word),
        .in_use   (ovf)
    );

    // Route the full-accumulator result or a raw partial word.
    always_comb begin
        unique case (src_sel_e'(src_sel))
            SRC_FULL: begin
                pre_trunc = lim_word;
                limited   = ovf;
            end
            SRC_HIGH: begin
                pre_trunc = acc_in[2*WORD_W-1:WORD_W];
                limited   = 1'b0;
            end
            default: begin
                pre_trunc = acc_in[WORD_W-1:0];
                limited   = 1'b0;
            end
        endcase
    end

    // Keep only the narrow field when the destination is 16 bits.
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                if (dst_narrow)
                    data_out = {{PAD_W{1'b0}}, pre_trunc[NARROW_W-1:0]};
                else
                    data_out = pre_trunc;
            end
        end else begin : g_nopad
            always_comb data_out = pre_trunc;
        end
    endgenerate
endmodule

// File: rtl/acc_widener.sv
// acc_widener: write-side widening of a 16- or 24-bit source.
// Assumes a 16-bit source sits in the low bits of the source word.
module acc_widener #(
    parameter int EXT_W    = 8,
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 16
) (
    input  logic [WORD_W-1:0]         src,
    input  logic                      src_narrow,
    output logic [EXT_W+2*WORD_W-1:0] acc_out,
    output logic [WORD_W-1:0]         reg_out
);
    localparam int PAD_W = WORD_W - NARROW_W;

    logic [WORD_W-1:0] word24;

    // Zero-extend a narrow source to a full word; keep a word source as is.
    always_comb begin
        if (src_narrow)
            word24 = {{PAD_W{1'b0}}, src[NARROW_W-1:0]};
        else
            word24 = src;
    end

    // Produce both destination forms from the common word.
    always_comb begin
        reg_out = word24;
        acc_out = {{EXT_W{word24[WORD_W-1]}}, word24, {WORD_W{1'b0}}};
    end
endmodule

// File: rtl/cc_flag_reg.sv
// cc_flag_reg: condition-code flag register with a sticky limit bit.
// Assumes a direct load outranks limit setting, which outranks clearing.
module cc_flag_reg #(
    parameter int FLAG_W = 7,
    parameter int L_IDX  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FLAG_W-1:0] load_val,
    input  logic              limit_evt,
    input  logic              clear_l,
    output logic [FLAG_W-1:0] flags
);
    // Update the flags on each edge by priority: reset, load, limit, clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else if (load)
            flags <= load_val;
        else if (limit_evt)
            flags[L_IDX] <= 1'b1;
        else if (clear_l)
            flags[L_IDX] <= 1'b0;
    end
endmodule

// File: rtl/acc_move_unit.sv
// acc_move_unit: top of the accumulator move data path.
// Assumes one read-side and one write-side transfer per cycle, already decoded.
module acc_move_unit #(
    parameter int EXT_W    = 8,
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_valid,
    input  logic [1:0]                rd_src_sel,
    input  logic [1:0]                scale_mode,
    input  logic                      rd_dst_narrow,
    input  logic [EXT_W+2*WORD_W-1:0] rd_acc,
    output logic [WORD_W-1:0]         rd_data,
    output logic                      rd_limited,
    input  logic [WORD_W-1:0]         wr_src,
    input  logic                      wr_src_narrow,
    input  logic                      wr_to_acc,
    output logic [EXT_W+2*WORD_W-1:0] wr_acc,
    output logic [WORD_W-1:0]         wr_reg,
    input  logic                      ccr_load,
    input  logic                      l_clear,
    output logic [6:0]                cc_flags
);
    import acc_mv_pkg::*;

    logic limit_evt;

    acc_read_path #(.EXT_W(EXT_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_rd (
        .acc_in     (rd_acc),
        .src_sel    (rd_src_sel),
        .mode       (scale_mode),
        .dst_narrow (rd_dst_narrow),
        .data_out   (rd_data),
        .limited    (rd_limited)
    );

    acc_widener #(.EXT_W(EXT_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_wr (
        .src        (wr_src),
        .src_narrow (wr_src_narrow),
        .acc_out    (wr_acc),
        .reg_out    (wr_reg)
    );

    // Only a real read that limits may set the sticky flag.
    always_comb limit_evt = rd_valid && rd_limited;

    cc_flag_reg #(.FLAG_W(FLAG_W), .L_IDX(FLAG_L)) u_cc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ccr_load),
        .load_val  (wr_src[FLAG_W-1:0]),
        .limit_evt (limit_evt),
        .clear_l   (l_clear),
        .flags     (cc_flags)
    );
endmodule

// File: rtl/acc_move_chk.sv
// acc_move_chk: temporal checks on acc_move_unit, attached with bind below.
// Assumes default-like geometry where bit 6 of the flags is the limit flag.
module acc_move_chk #(
    parameter int EXT_W    = 8,
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rd_valid,
    input logic [1:0]                rd_src_sel,
    input logic                      rd_dst_narrow,
    input logic [WORD_W-1:0]         rd_data,
    input logic                      rd_limited,
    input logic [WORD_W-1:0]         wr_src,
    input logic                      wr_src_narrow,
    input logic                      wr_to_acc,
    input logic [EXT_W+2*WORD_W-1:0] wr_acc,
    input logic [WORD_W-1:0]         wr_reg,
    input logic                      ccr_load,
    input logic                      l_clear,
    input logic [6:0]                cc_flags
);
    localparam logic [WORD_W-1:0] POS_C = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_C = {1'b1, {(WORD_W-1){1'b0}}};

    a_r3_sat_const: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_limited && !rd_dst_narrow) |-> (rd_data == POS_C || rd_data == NEG_C));

    a_r4_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dst_narrow |-> (rd_data[WORD_W-1:NARROW_W] == '0));

    a_r5_part_no_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_src_sel != 2'b00) |-> !rd_limited);

    a_r6_l_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_limited && !ccr_load) |=> cc_flags[6]);

    a_r6_l_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_flags[6] && !l_clear && !ccr_load) |=> cc_flags[6]);

    a_r7_acc_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (wr_acc[WORD_W-1:0] == '0));

    a_r9_narrow_ext_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_src_narrow && wr_to_acc) |-> (wr_acc[EXT_W+2*WORD_W-1:WORD_W+NARROW_W] == '0));

    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_load |=> (cc_flags == $past(wr_src[6:0])));

    a_r11_others_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ccr_load |=> $stable(cc_flags[5:0]));
endmodule

bind acc_move_unit acc_move_chk #(.EXT_W(EXT_W), .WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_valid      (rd_valid),
    .rd_src_sel    (rd_src_sel),
    .rd_dst_narrow (rd_dst_narrow),
    .rd_data       (rd_data),
    .rd_limited    (rd_limited),
    .wr_src        (wr_src),
    .wr_src_narrow (wr_src_narrow),
    .wr_to_acc     (wr_to_acc),
    .wr_acc        (wr_acc),
    .wr_reg        (wr_reg),
    .ccr_load      (ccr_load),
    .l_clear       (l_clear),
    .cc_flags      (cc_flags)
);

// File: tb/tb_acc_move_unit.sv
// tb_acc_move_unit: vector table for the read path, then directed tests.
module tb_acc_move_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    typedef struct packed {
        logic [1:0]  sel;
        logic [1:0]  mode;
        logic        narrow;
        logic [55:0] acc;
        logic [23:0] exp_data;
        logic        exp_lim;
    } vec_t;

    // sel: 0 full, 1 high, 2 low; mode: 0 none, 1 right, 2 left, 3 none
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 2'd0, 1'b0, 56'h00_123456_ABCDEF, 24'h123456, 1'b0}, // R2 fits
        '{2'd0, 2'd0, 1'b0, 56'h01_000000_000000, 24'h7FFFFF, 1'b1}, // R3 pos
        '{2'd0, 2'd0, 1'b0, 56'hFE_000000_000000, 24'h800000, 1'b1}, // R3 neg
        '{2'd0, 2'd0, 1'b0, 56'hFF_800000_000000, 24'h800000, 1'b0}, // R2 edge
        '{2'd0, 2'd1, 1'b0, 56'h00_FFFFFE_000000, 24'h7FFFFF, 1'b0}, // R1 right
        '{2'd0, 2'd2, 1'b0, 56'h00_400000_000000, 24'h7FFFFF, 1'b1}, // R1 left ovf
        '{2'd0, 2'd2, 1'b0, 56'h00_123456_800000, 24'h2468AD, 1'b0}, // R1 left carry
        '{2'd0, 2'd3, 1'b0, 56'h00_400000_000000, 24'h400000, 1'b0}, // R1 code 11
        '{2'd0, 2'd0, 1'b1, 56'h00_123456_000000, 24'h003456, 1'b0}, // R4 fits
        '{2'd0, 2'd0, 1'b1, 56'h05_000000_000000, 24'h00FFFF, 1'b1}, // R4 pos sat
        '{2'd0, 2'd0, 1'b1, 56'h80_000000_000000, 24'h000000, 1'b1}, // R4 neg sat
        '{2'd1, 2'd2, 1'b0, 56'h7F_ABCDEF_123456, 24'hABCDEF, 1'b0}, // R5 high
        '{2'd2, 2'd1, 1'b0, 56'h7F_ABCDEF_123456, 24'h123456, 1'b0}, // R5 low
        '{2'd1, 2'd0, 1'b1, 56'h7F_ABCDEF_123456, 24'h00CDEF, 1'b0}  // R5 narrow
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [1:0]  rd_src_sel = 2'd0;
    logic [1:0]  scale_mode = 2'd0;
    logic        rd_dst_narrow = 1'b0;
    logic [55:0] rd_acc = '0;
    logic [23:0] rd_data;
    logic        rd_limited;
    logic [23:0] wr_src = '0;
    logic        wr_src_narrow = 1'b0;
    logic        wr_to_acc = 1'b0;
    logic [55:0] wr_acc;
    logic [23:0] wr_reg;
    logic        ccr_load = 1'b0;
    logic        l_clear = 1'b0;
    logic [6:0]  cc_flags;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_move_unit dut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_src_sel(rd_src_sel),
        .scale_mode(scale_mode), .rd_dst_narrow(rd_dst_narrow), .rd_acc(rd_acc),
        .rd_data(rd_data), .rd_limited(rd_limited), .wr_src(wr_src),
        .wr_src_narrow(wr_src_narrow), .wr_to_acc(wr_to_acc), .wr_acc(wr_acc),
        .wr_reg(wr_reg), .ccr_load(ccr_load), .l_clear(l_clear), .cc_flags(cc_flags)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge, one edge past a rising edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        rd_valid = 1'b0; ccr_load = 1'b0; l_clear = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rd_acc = 56'h01_000000_000000; rd_valid = 1'b1;
        step();
        check("R12 flags in reset", 64'(cc_flags), 64'h0);
        rd_valid = 1'b0;
        rst_n = 1'b1;
        step();

        // Vector table: clear L, then one valid read per vector.
        for (int i = 0; i < NVEC; i++) begin
            l_clear = 1'b1;
            step();
            l_clear = 1'b0;
            rd_src_sel = VECS[i].sel; scale_mode = VECS[i].mode;
            rd_dst_narrow = VECS[i].narrow; rd_acc = VECS[i].acc; rd_valid = 1'b1;
            #1;
            check($sformatf("R1/R2/R3/R4/R5 data vec%0d", i), 64'(rd_data), 64'(VECS[i].exp_data));
            check($sformatf("R3/R5 limited vec%0d", i), 64'(rd_limited), 64'(VECS[i].exp_lim));
            step();
            rd_valid = 1'b0;
            check($sformatf("R6 L after vec%0d", i), 64'(cc_flags[6]), 64'(VECS[i].exp_lim));
        end

        // R6: sticky through non-limiting moves and invalid limiting input.
        idle(); rd_src_sel = 2'd0; scale_mode = 2'd0; rd_dst_narrow = 1'b0;
        l_clear = 1'b1; step(); l_clear = 1'b0;
        rd_acc = 56'h02_000000_000000; rd_valid = 1'b0;
        step();
        check("R6 no set without rd_valid", 64'(cc_flags[6]), 64'h0);
        rd_valid = 1'b1; step();
        rd_acc = 56'h00_000001_000000;
        step(); step();
        check("R6 L sticky after fitting moves", 64'(cc_flags[6]), 64'h1);
        rd_acc = 56'h02_000000_000000; l_clear = 1'b1;
        step();
        check("R6 set wins over clear", 64'(cc_flags[6]), 64'h1);
        rd_valid = 1'b0;
        step();
        check("R6 clear", 64'(cc_flags[6]), 64'h0);

        // R11: direct flag load, and priority over a limiting read.
        idle(); wr_src = 24'hFFFF2A; ccr_load = 1'b1;
        step();
        check("R11 load flags", 64'(cc_flags), 64'h2A);
        wr_src = 24'h000015; rd_acc = 56'h02_000000_000000; rd_valid = 1'b1; l_clear = 1'b1;
        step();
        check("R11 load beats limit", 64'(cc_flags), 64'h15);
        idle(); rd_valid = 1'b1;
        step();
        check("R11 E..C kept on limit", 64'(cc_flags), 64'h55);

        // Write side, combinational.
        idle();
        wr_src = 24'h812345; wr_src_narrow = 1'b0; wr_to_acc = 1'b1; #1;
        check("R7 neg word to acc", wr_acc, 64'h00FF_8123_4500_0000);
        check("R10 word to reg", 64'(wr_reg), 64'h812345);
        wr_src = 24'h7FFFFF; #1;
        check("R7 pos word to acc", wr_acc, 64'h0000_7FFF_FF00_0000);
        wr_src = 24'hFFABCD; wr_src_narrow = 1'b1; wr_to_acc = 1'b0; #1;
        check("R8 narrow to reg", 64'(wr_reg), 64'h00ABCD);
        wr_src = 24'hFF8000; wr_to_acc = 1'b1; #1;
        check("R9 narrow to acc", wr_acc, 64'h0000_0080_0000_0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule